// File: doc/BRIEF.md
# Split-Accumulator Multiply Unit

This block multiplies two 32-bit operands and keeps a 64-bit accumulator made of two 32-bit halves. The upper half is the high accumulator word and the lower half is the low accumulator word. It supports seven operations:

- full 64-bit products, signed or unsigned, written to both halves;
- a 32-bit truncated product written to the low half only;
- 16x16 products of the operands' low halves, signed or unsigned, written to the low half only;
- signed 32x32 multiply-accumulate into the full 64-bit value;
- signed 16x16 multiply-accumulate into the full 64-bit value.

A saturation mode changes how the two accumulate operations limit their result. Software can clear both halves or write either half directly. Both halves are always visible as outputs.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After that, `req_ready` stays low for one cycle. A request held during that cycle is not taken and leaves no trace. The caller must keep it asserted until it sees ready high again. The result of a request shows on the accumulator outputs in the same cycle as a one-cycle `done` pulse. That pulse comes two edges after the accepting edge. The next request may be taken on the edge that ends the `done` cycle. There is no back-pressure on the result side.

Top module: `mac_unit`

## Requirements
- R1: After reset both accumulator halves read zero, `done` is low and `req_ready` is high.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low for exactly the next cycle, and a request presented then is ignored. `done` is high for exactly one cycle, beginning after the second edge following acceptance. The result shows in that cycle, and `req_ready` is high again.
- R3: Operation code 0 writes the signed 64-bit product of `req_a` and `req_b`: bits 63..32 go to `mach` and bits 31..0 go to `macl`.
- R4: Operation code 1 does the same with both operands treated as unsigned.
- R5: Operation code 2 writes the low 32 bits of `req_a*req_b` to `macl` and leaves `mach` unchanged.
- R6: Operation codes 3 and 4 multiply bits 15..0 of each operand, signed for 3 and unsigned for 4. They write the 32-bit product to `macl` and leave `mach` unchanged.
- R7: Operation code 5 with saturation off adds the signed 64-bit product to {`mach`,`macl`}, wrapping modulo 2^64.
- R8: Operation code 5 with saturation on clamps the exact sum to the range 0xFFFF8000_00000000 to 0x00007FFF_FFFFFFFF.
- R9: Operation code 6 with saturation off sign-extends the signed 16x16 product and adds it to {`mach`,`macl`}, wrapping modulo 2^64.
- R10: Operation code 6 with saturation on adds the product to `macl` as a signed 32-bit value. On overflow `macl` is clamped to 0x7FFFFFFF or 0x80000000 and bit 0 of `mach` is set; otherwise `mach` is unchanged.
- R11: `sat_mode` is sampled on the accepting edge; changing it afterwards has no effect on that request.
- R12: `acc_clr` zeroes both halves on the edge where it is high. It overrides direct writes and a completing operation.
- R13: `hi_we` and `lo_we` load their half from `hi_wdata` or `lo_wdata` on the edge where they are high. Each overrides a completing operation for its own half only; the other half still takes the operation's result.
- R14: Operation code 7 is taken and pulses `done` but changes neither half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 3 | Operation code 0..7 |
| req_a | input | 32 | First operand |
| req_b | input | 32 | Second operand |
| sat_mode | input | 1 | Saturation mode for accumulate codes |
| done | output | 1 | One-cycle completion pulse |
| acc_clr | input | 1 | Clear both halves |
| hi_we | input | 1 | Direct write of the high half |
| hi_wdata | input | 32 | Data for the high half |
| lo_we | input | 1 | Direct write of the low half |
| lo_wdata | input | 32 | Data for the low half |
| mach | output | 32 | High accumulator half |
| macl | output | 32 | Low accumulator half |

## Verification
The bench sweeps every operation over a grid of extreme operands, including 0x80000000 x 0x80000000, 0x8000 in the low half and all-ones. It does this against preloaded accumulators that sit just inside the 48-bit and 32-bit clamp limits. A design that mixed up sign and zero extension, or that wrapped where it should clamp, would miss the arithmetic expectation, and one that forgot to keep the high half for the narrow codes would lose the preloaded pattern. Separate cases flip the saturation input during the busy cycle, clear or write halves exactly on the completing edge, and hold a request while ready is low; a design that resampled the mode, gave an operation precedence over a write, or took the held request would leave a visibly wrong accumulator.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_SMUL_L = 3'd0,
    OP_UMUL_L = 3'd1,
    OP_MUL_TR = 3'd2,
    OP_SMUL_W = 3'd3,
    OP_UMUL_W = 3'd4,
    OP_MAC_L  = 3'd5,
    OP_MAC_W  = 3'd6,
    OP_NONE   = 3'd7
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  mac_op_e          in_op,
  input  logic             in_sat,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  output logic             out_valid,
  output mac_op_e          out_op,
  output logic             out_sat,
  output logic [2*W-1:0]   out_prod
);
  localparam int HW = W / 2;
  localparam int PW = 2 * W;

  logic half_sel, sgn_sel;
  always_comb begin
    half_sel = (in_op == OP_SMUL_W) || (in_op == OP_UMUL_W) || (in_op == OP_MAC_W);
    sgn_sel  = !((in_op == OP_UMUL_L) || (in_op == OP_UMUL_W));
  end

  logic [W-1:0]  opnd [2];
  logic [W:0]    opx  [2];
  logic [PW-1:0] opw  [2];
  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  // operand conditioning: pick width and signedness, then widen to product width
  for (genvar gi = 0; gi < 2; gi++) begin : g_ext
    assign opx[gi] = half_sel
      ? {{(W-HW+1){sgn_sel & opnd[gi][HW-1]}}, opnd[gi][HW-1:0]}
      : {sgn_sel & opnd[gi][W-1], opnd[gi]};
    assign opw[gi] = {{(W-1){opx[gi][W]}}, opx[gi]};
  end

  logic [PW-1:0] prod;
  assign prod = opw[0] * opw[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_op    <= OP_NONE;
      out_sat   <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_op   <= in_op;
        out_sat  <= in_sat;
        out_prod <= prod;
      end
    end
  end

  assert_stage_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_sat_captured_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_sat == $past(in_sat)));
endmodule

// File: rtl/mac_combine.sv
module mac_combine
  import mac_pkg::*;
#(
  parameter int W        = 32,
  parameter int SAT_BITS = 48
) (
  input  mac_op_e          op,
  input  logic             sat,
  input  logic [2*W-1:0]   prod,
  input  logic [2*W-1:0]   acc,
  output logic [2*W-1:0]   nxt,
  output logic             we_hi,
  output logic             we_lo
);
  localparam int AW = 2 * W;
  localparam int XW = AW + 2;
  localparam logic signed [XW-1:0] SAT_MAX = {{(XW-SAT_BITS+1){1'b0}}, {(SAT_BITS-1){1'b1}}};
  localparam logic signed [XW-1:0] SAT_MIN = {{(XW-SAT_BITS+1){1'b1}}, {(SAT_BITS-1){1'b0}}};
  localparam logic [W-1:0] WMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] WMIN = {1'b1, {(W-1){1'b0}}};

  logic signed [XW-1:0] sum_x;
  logic [W:0]           wsum;
  logic                 w_ovf;

  assign sum_x = $signed({{2{acc[AW-1]}}, acc}) + $signed({{2{prod[AW-1]}}, prod});
  assign wsum  = {acc[W-1], acc[W-1:0]} + {prod[W-1], prod[W-1:0]};
  assign w_ovf = wsum[W] ^ wsum[W-1];

  always_comb begin
    nxt   = acc;
    we_hi = 1'b0;
    we_lo = 1'b0;
    case (op)
      OP_SMUL_L, OP_UMUL_L: begin
        nxt   = prod;
        we_hi = 1'b1;
        we_lo = 1'b1;
      end
      OP_MUL_TR, OP_SMUL_W, OP_UMUL_W: begin
        nxt   = {acc[AW-1:W], prod[W-1:0]};
        we_lo = 1'b1;
      end
      OP_MAC_L: begin
        we_hi = 1'b1;
        we_lo = 1'b1;
        if (sat && (sum_x > SAT_MAX))      nxt = SAT_MAX[AW-1:0];
        else if (sat && (sum_x < SAT_MIN)) nxt = SAT_MIN[AW-1:0];
        else                               nxt = sum_x[AW-1:0];
      end
      OP_MAC_W: begin
        we_hi = 1'b1;
        we_lo = 1'b1;
        if (!sat)       nxt = sum_x[AW-1:0];
        else if (w_ovf) nxt = {acc[AW-1:W+1], 1'b1, (wsum[W] ? WMIN : WMAX)};
        else            nxt = {acc[AW-1:W], wsum[W-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int W        = 32,
  parameter int SAT_BITS = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [2:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  input  logic         sat_mode,
  output logic         done,
  input  logic         acc_clr,
  input  logic         hi_we,
  input  logic [W-1:0] hi_wdata,
  input  logic         lo_we,
  input  logic [W-1:0] lo_wdata,
  output logic [W-1:0] mach,
  output logic [W-1:0] macl
);
  localparam int AW = 2 * W;
  localparam logic signed [AW-1:0] LIM_HI = {{(AW-SAT_BITS+1){1'b0}}, {(SAT_BITS-1){1'b1}}};
  localparam logic signed [AW-1:0] LIM_LO = {{(AW-SAT_BITS+1){1'b1}}, {(SAT_BITS-1){1'b0}}};

  logic           accept;
  logic           s1_valid;
  mac_op_e        s1_op;
  logic           s1_sat;
  logic [AW-1:0]  s1_prod;
  logic [AW-1:0]  nxt;
  logic           cw_hi, cw_lo;

  assign accept    = req_valid && req_ready;
  assign req_ready = !s1_valid;

  mac_mult #(.W(W)) u_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (accept),
    .in_op    (mac_op_e'(req_op)),
    .in_sat   (sat_mode),
    .in_a     (req_a),
    .in_b     (req_b),
    .out_valid(s1_valid),
    .out_op   (s1_op),
    .out_sat  (s1_sat),
    .out_prod (s1_prod)
  );

  mac_combine #(.W(W), .SAT_BITS(SAT_BITS)) u_comb (
    .op   (s1_op),
    .sat  (s1_sat),
    .prod (s1_prod),
    .acc  ({mach, macl}),
    .nxt  (nxt),
    .we_hi(cw_hi),
    .we_lo(cw_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= s1_valid;
  end

  // per half: clear, then direct write, then completing operation
  always_ff @(posedge clk) begin
    if (!rst_n || acc_clr) begin
      mach <= '0;
      macl <= '0;
    end else begin
      if (hi_we)                 mach <= hi_wdata;
      else if (s1_valid && cw_hi) mach <= nxt[AW-1:W];
      if (lo_we)                 macl <= lo_wdata;
      else if (s1_valid && cw_lo) macl <= nxt[W-1:0];
    end
  end

  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 done);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_narrow_keeps_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !acc_clr && !hi_we &&
     (s1_op == OP_MUL_TR || s1_op == OP_SMUL_W || s1_op == OP_UMUL_W)) |=> $stable(mach));
  assert_long_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_op == OP_MAC_L && s1_sat && !acc_clr && !hi_we && !lo_we)
      |=> ($signed({mach, macl}) <= LIM_HI && $signed({mach, macl}) >= LIM_LO));
  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (mach == '0 && macl == '0));
  assert_hi_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !acc_clr) |=> (mach == $past(hi_wdata)));
  assert_lo_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !acc_clr) |=> (macl == $past(lo_wdata)));
endmodule

// File: tb/mac_unit_test.sv
module mac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] req_a = '0, req_b = '0;
  logic        sat_mode = 1'b0;
  logic        done;
  logic        acc_clr = 1'b0;
  logic        hi_we = 1'b0, lo_we = 1'b0;
  logic [31:0] hi_wdata = '0, lo_wdata = '0;
  logic [31:0] mach, macl;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mac_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .sat_mode(sat_mode),
    .done(done), .acc_clr(acc_clr), .hi_we(hi_we), .hi_wdata(hi_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .mach(mach), .macl(macl)
  );

  localparam logic signed [65:0] LMAX = 66'sh7FFF_FFFF_FFFF;
  localparam logic signed [65:0] LMIN = -66'sh8000_0000_0000;

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h1234_8000, 32'hFFFF_7FFF, 32'h0001_0000};
  logic [63:0] accs [5] = '{64'h0, 64'h0000_7FFF_FFFF_FFF0, 64'hFFFF_8000_0000_0010,
                            64'h1234_5678_7FFF_FFF0, 64'hFFFF_FFFF_8000_0005};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input int op, input logic [63:0] acc,
                                        input logic [31:0] a, input logic [31:0] b, input bit s);
    logic [63:0] sa, sb, ua, ub, p;
    logic [31:0] pw;
    logic signed [65:0] sum;
    logic [32:0] ws;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'h0, a};
    ub = {32'h0, b};
    pw = {{16{a[15]}}, a[15:0]} * {{16{b[15]}}, b[15:0]};
    case (op)
      0: return sa * sb;
      1: return ua * ub;
      2: return {acc[63:32], a * b};
      3: return {acc[63:32], pw};
      4: begin
        pw = {16'h0, a[15:0]} * {16'h0, b[15:0]};
        return {acc[63:32], pw};
      end
      5: begin
        p = sa * sb;
        if (!s) return acc + p;
        sum = $signed({{2{acc[63]}}, acc}) + $signed({{2{p[63]}}, p});
        if (sum > LMAX) return 64'h0000_7FFF_FFFF_FFFF;
        if (sum < LMIN) return 64'hFFFF_8000_0000_0000;
        return sum[63:0];
      end
      6: begin
        p = {{32{pw[31]}}, pw};
        if (!s) return acc + p;
        ws = {acc[31], acc[31:0]} + {pw[31], pw};
        if (ws[32] != ws[31])
          return {acc[63:33], 1'b1, (ws[32] ? 32'h8000_0000 : 32'h7FFF_FFFF)};
        return {acc[63:32], ws[31:0]};
      end
      default: return acc;
    endcase
  endfunction

  function automatic string tag_of(input int op, input bit s);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      5: return s ? "R8" : "R7";
      6: return s ? "R10" : "R9";
      default: return "R14";
    endcase
  endfunction

  // entered and left at a falling edge
  task automatic preload(input logic [63:0] v);
    hi_we = 1'b1; lo_we = 1'b1;
    hi_wdata = v[63:32]; lo_wdata = v[31:0];
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
    chk({mach, macl} == v, "R13 direct write", {mach, macl}, v);
  endtask

  task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b, input bit s,
                        input bit flip, input bit clr, input bit hwe, input bit lwe,
                        input logic [31:0] hd, input logic [31:0] ld);
    logic [63:0] exp;
    string tg;
    exp = model(op, {mach, macl}, a, b, s);
    tg  = tag_of(op, s);
    if (clr) begin
      exp = '0; tg = "R12";
    end else begin
      if (hwe) begin exp[63:32] = hd; tg = "R13"; end
      if (lwe) begin exp[31:0]  = ld; tg = "R13"; end
    end
    if (flip) tg = "R11";
    chk(req_ready, "R2 ready idle", {63'h0, req_ready}, 64'h1);
    req_valid = 1'b1; req_op = op[2:0]; req_a = a; req_b = b; sat_mode = s;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !done, "R2 busy cycle", {62'h0, req_ready, done}, 64'h0);
    sat_mode = flip ? !s : s;
    acc_clr = clr; hi_we = hwe; lo_we = lwe; hi_wdata = hd; lo_wdata = ld;
    @(negedge clk);
    acc_clr = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    chk(done && req_ready, "R2 done cycle", {62'h0, done, req_ready}, 64'h3);
    chk({mach, macl} == exp, tg, {mach, macl}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL R2 watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({mach, macl} == 64'h0, "R1 accumulator", {mach, macl}, 64'h0);
    chk(req_ready && !done, "R1 handshake", {62'h0, req_ready, done}, 64'h2);

    // narrow and full multiplies over the operand grid, high half preloaded
    for (int op = 0; op < 5; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          preload(accs[(i + j) % 5] ^ 64'hA5A5_0000_0000_0000);
          run_op(op, vals[i], vals[j], 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
        end

    // accumulate in both modes over accumulators near the clamp limits
    for (int op = 5; op < 7; op++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 5; k++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
              preload(accs[k]);
              run_op(op, vals[i], vals[j], s[0], 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
            end

    // R14 code 7 changes nothing
    preload(64'hDEAD_BEEF_0BAD_F00D);
    run_op(7, 32'h1234, 32'h5678, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);

    // R11 mode sampled on acceptance, both directions
    preload(64'h0000_7FFF_FFFF_FFF0);
    run_op(5, 32'h0001_0000, 32'h0001_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    preload(64'h0000_7FFF_FFFF_FFF0);
    run_op(5, 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    preload(64'h0000_0000_7FFF_FFF0);
    run_op(6, 32'h0000_0100, 32'h0000_0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);

    // R12 clear on the completing edge, also against simultaneous writes
    preload(64'h1111_2222_3333_4444);
    run_op(0, 32'h7, 32'h9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0);
    preload(64'h1111_2222_3333_4444);
    run_op(5, 32'h7, 32'h9, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'hAAAA_AAAA, 32'h5555_5555);

    // R13 per-half write priority over a completing operation
    preload(64'h0);
    run_op(0, 32'hFFFF_FFFF, 32'h2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 32'hCAFE_0001);
    preload(64'h0);
    run_op(1, 32'hFFFF_FFFF, 32'h2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hBEEF_0002, 32'h0);
    preload(64'h0000_0000_0000_0010);
    run_op(6, 32'h3, 32'h4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0102_0304, 32'h0506_0708);

    // R2 request held while busy is ignored
    preload(64'h0);
    req_valid = 1'b1; req_op = 3'd0; req_a = 32'd3; req_b = 32'd5; sat_mode = 1'b0;
    @(negedge clk);
    req_op = 3'd1; req_a = 32'd7; req_b = 32'd7;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && {mach, macl} == 64'd15, "R2 first result", {mach, macl}, 64'd15);
    @(negedge clk);
    chk(!done && {mach, macl} == 64'd15, "R2 held request ignored",
        {31'h0, done, mach, macl}, 64'd15);
    @(negedge clk);
    chk(!done && req_ready, "R2 stays idle", {62'h0, done, req_ready}, 64'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule